// File: doc/BRIEF.md
# GMII Byte Replication Rate Adapter

This block sits between a byte-wide GMII stream and a serial link that always runs at 125 MHz, so that 10 and 100 Mb/s traffic can share one clock with gigabit traffic. The clock frequency never changes. Instead, each byte is repeated on the line for a number of clock cycles that depends on the selected rate: 100 cycles at 10 Mb/s, 10 cycles at 100 Mb/s and 1 cycle at 1000 Mb/s.

On the transmit side, the user presents one byte with a strobe in each cycle in which the adapter shows a slot. The adapter then drives that byte, with its enable and error flags, for a whole replication period. On the receive side, the adapter counts replication periods from the first cycle of data-valid. It samples the middle cycle of each period, so a first byte that arrives shortened by a cycle or two is still taken correctly. Each sampled byte is presented with a one-cycle strobe.

Neither side has a frame buffer. Once a frame has started, the user must keep strobing bytes in every slot until it sends the end marker. A missing strobe aborts the frame and is flagged. The rate is taken from a 2-bit code and is latched only while both directions are quiet.

Top module: `gmii_rate_adapter`

## Requirements
- R1: After reset, the transmit line enable, error and data are 0, `tx_slot_o` is 1, and `rx_stb_o`, `rx_dv_o` and `tx_underrun_o` are 0.
- R2: The speed code selects the number of cycles each byte is held: bit 1 set gives 1 cycle, code 01 gives 10 cycles, and code 00 gives 100 cycles.
- R3: A strobe taken in a slot with `tx_en_i`=1 puts the byte and its error flag on `gmii_txd_o`/`gmii_tx_er_o`, with `gmii_tx_en_o`=1, from the next cycle. They stay unchanged for exactly one replication period.
- R4: `tx_slot_o` is 1 whenever the transmit line is idle. During a frame it is 1 only in the last cycle of each replication period.
- R5: A strobe taken in a slot with `tx_en_i`=0 ends the frame, and the line enable drops in the next cycle. A strobe with `tx_en_i`=0 while the line is idle has no effect. A strobe made while `tx_slot_o`=0 is ignored.
- R6: If a frame is active and no strobe arrives in a slot, the line enable, error and data all go to 0 in the next cycle, and `tx_underrun_o` pulses high for exactly one cycle.
- R7: On receive, the replication phase is 0 in the first cycle that `gmii_rx_dv_i` is high and advances by one per cycle, modulo the period. The byte and error flag at phase period/2 (50, 5 or 0) appear on `rx_data_o`/`rx_er_o` in the next cycle, with a one-cycle `rx_stb_o`.
- R8: A first received byte that is up to two cycles shorter than a full period at 10 or 100 Mb/s still yields the correct byte sequence.
- R9: `rx_dv_o` rises together with the first `rx_stb_o` of a frame. It falls in the cycle after `gmii_rx_dv_i` goes low.
- R10: A new speed code takes effect only in a cycle in which the transmit line is idle, no frame start is strobed, and the receive data-valid is low both at the input and as registered in the previous cycle. A change made during a frame is applied only after that frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock for both directions |
| rst | input | 1 | Synchronous active-high reset |
| speed_i | input | 2 | Rate code: 1x = 1000, 01 = 100, 00 = 10 Mb/s |
| tx_stb_i | input | 1 | User strobe offering one transmit byte |
| tx_en_i | input | 1 | Frame-active flag with the strobed byte (0 ends the frame) |
| tx_er_i | input | 1 | Error flag with the strobed byte |
| tx_data_i | input | 8 | Strobed transmit byte |
| tx_slot_o | output | 1 | Adapter takes a strobe in this cycle |
| tx_underrun_o | output | 1 | One-cycle pulse when a frame is aborted for a missing strobe |
| gmii_txd_o | output | 8 | Replicated transmit byte |
| gmii_tx_en_o | output | 1 | Replicated transmit enable |
| gmii_tx_er_o | output | 1 | Replicated transmit error |
| gmii_rxd_i | input | 8 | Replicated receive byte |
| gmii_rx_dv_i | input | 1 | Replicated receive data-valid |
| gmii_rx_er_i | input | 1 | Replicated receive error |
| rx_stb_o | output | 1 | One-cycle strobe for each recovered byte |
| rx_data_o | output | 8 | Recovered receive byte |
| rx_er_o | output | 1 | Error flag sampled with the byte |
| rx_dv_o | output | 1 | Recovered frame active |

## Verification
The assertions assume that the user sees the slot in time and changes the speed code only between frames, or else lets the adapter defer the change. They also assume that each received byte is held for its full period apart from a shortened first byte. The bench drives every transmit byte on a cycle in which it has seen `tx_slot_o` high, holds received bytes for exact periods, and shortens only the first byte by two cycles. It also makes deliberate strobes outside the slot, idle end markers, a missing strobe and mid-frame speed changes, in order to show that each of these is ignored, flagged or deferred.

// File: rtl/gra_pkg.sv
package gra_pkg;
  localparam int BYTE_W = 8;

  // One line beat: flags plus byte
  typedef struct packed {
    logic              en;
    logic              er;
    logic [BYTE_W-1:0] data;
  } gra_beat_t;

  // Replication length for a rate code
  function automatic int unsigned gra_reps(input logic [1:0] code,
                                           input int unsigned slow_reps,
                                           input int unsigned mid_reps);
    if (code[1])      return 1;
    else if (code[0]) return mid_reps;
    else              return slow_reps;
  endfunction
endpackage

// File: rtl/gra_speed_lock.sv
module gra_speed_lock #(
  parameter logic [1:0] RESET_CODE = 2'b10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] speed_i,
  input  logic       quiet_i,
  output logic [1:0] speed_o
);
  always_ff @(posedge clk) begin
    if (rst)          speed_o <= RESET_CODE;
    else if (quiet_i) speed_o <= speed_i;
  end
endmodule

// File: rtl/gra_tx_path.sv
module gra_tx_path
  import gra_pkg::*;
#(
  parameter int unsigned SLOW_REPS = 100,
  parameter int unsigned MID_REPS  = 10,
  parameter int unsigned CNT_W     = $clog2(SLOW_REPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        speed_i,
  input  logic              stb_i,
  input  logic              en_i,
  input  logic              er_i,
  input  logic [BYTE_W-1:0] data_i,
  output gra_beat_t         beat_o,
  output logic              slot_o,
  output logic              underrun_o
);
  logic [CNT_W-1:0] hold_cnt;
  logic [CNT_W-1:0] reload;

  assign reload = CNT_W'(gra_reps(speed_i, SLOW_REPS, MID_REPS) - 1);
  assign slot_o = (hold_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt   <= '0;
      beat_o     <= '0;
      underrun_o <= 1'b0;
    end else begin
      underrun_o <= 1'b0;
      if (slot_o) begin
        if (stb_i && (en_i || beat_o.en)) begin
          beat_o.en   <= en_i;
          beat_o.er   <= en_i & er_i;
          beat_o.data <= en_i ? data_i : '0;
          hold_cnt    <= en_i ? reload : '0;
        end else if (beat_o.en) begin
          beat_o     <= '0;
          hold_cnt   <= '0;
          underrun_o <= 1'b1;
        end
      end else begin
        hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/gra_rx_path.sv
module gra_rx_path
  import gra_pkg::*;
#(
  parameter int unsigned SLOW_REPS = 100,
  parameter int unsigned MID_REPS  = 10,
  parameter int unsigned CNT_W     = $clog2(SLOW_REPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        speed_i,
  input  logic [BYTE_W-1:0] rxd_i,
  input  logic              dv_i,
  input  logic              er_i,
  output logic              stb_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              er_o,
  output logic              dv_o,
  output logic              busy_o
);
  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] phase_cur;
  logic [CNT_W-1:0] last_ph;
  logic [CNT_W-1:0] mid_ph;
  logic             dv_q;
  logic             take;

  assign last_ph   = CNT_W'(gra_reps(speed_i, SLOW_REPS, MID_REPS) - 1);
  assign mid_ph    = CNT_W'(gra_reps(speed_i, SLOW_REPS, MID_REPS) / 2);
  // Phase restarts on the first valid cycle of a frame
  assign phase_cur = (dv_i && !dv_q) ? '0 : phase_q;
  assign take      = dv_i && (phase_cur == mid_ph);
  assign busy_o    = dv_i | dv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q    <= 1'b0;
      phase_q <= '0;
      stb_o   <= 1'b0;
      data_o  <= '0;
      er_o    <= 1'b0;
      dv_o    <= 1'b0;
    end else begin
      dv_q    <= dv_i;
      phase_q <= (!dv_i || phase_cur == last_ph) ? '0 : phase_cur + 1'b1;
      stb_o   <= take;
      if (take) begin
        data_o <= rxd_i;
        er_o   <= er_i;
      end
      dv_o <= dv_i & (dv_o | take);
    end
  end
endmodule

// File: rtl/gmii_rate_adapter.sv
module gmii_rate_adapter
  import gra_pkg::*;
#(
  parameter int unsigned SLOW_REPS = 100,
  parameter int unsigned MID_REPS  = 10,
  localparam int unsigned CNT_W    = $clog2(SLOW_REPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        speed_i,
  input  logic              tx_stb_i,
  input  logic              tx_en_i,
  input  logic              tx_er_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              tx_slot_o,
  output logic              tx_underrun_o,
  output logic [BYTE_W-1:0] gmii_txd_o,
  output logic              gmii_tx_en_o,
  output logic              gmii_tx_er_o,
  input  logic [BYTE_W-1:0] gmii_rxd_i,
  input  logic              gmii_rx_dv_i,
  input  logic              gmii_rx_er_i,
  output logic              rx_stb_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_er_o,
  output logic              rx_dv_o
);
  logic [1:0] speed_q;
  logic       rx_busy;
  logic       quiet;
  gra_beat_t  tx_beat;

  assign quiet = !tx_beat.en && !(tx_stb_i && tx_en_i) && !rx_busy;

  gra_speed_lock u_lock (
    .clk     (clk),
    .rst     (rst),
    .speed_i (speed_i),
    .quiet_i (quiet),
    .speed_o (speed_q)
  );

  gra_tx_path #(.SLOW_REPS(SLOW_REPS), .MID_REPS(MID_REPS), .CNT_W(CNT_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .speed_i    (speed_q),
    .stb_i      (tx_stb_i),
    .en_i       (tx_en_i),
    .er_i       (tx_er_i),
    .data_i     (tx_data_i),
    .beat_o     (tx_beat),
    .slot_o     (tx_slot_o),
    .underrun_o (tx_underrun_o)
  );

  assign gmii_txd_o   = tx_beat.data;
  assign gmii_tx_en_o = tx_beat.en;
  assign gmii_tx_er_o = tx_beat.er;

  gra_rx_path #(.SLOW_REPS(SLOW_REPS), .MID_REPS(MID_REPS), .CNT_W(CNT_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .speed_i (speed_q),
    .rxd_i   (gmii_rxd_i),
    .dv_i    (gmii_rx_dv_i),
    .er_i    (gmii_rx_er_i),
    .stb_o   (rx_stb_o),
    .data_o  (rx_data_o),
    .er_o    (rx_er_o),
    .dv_o    (rx_dv_o),
    .busy_o  (rx_busy)
  );
endmodule

// File: rtl/gra_checker.sv
module gra_checker (
  input logic       clk,
  input logic       rst,
  input logic       tx_slot_o,
  input logic       tx_underrun_o,
  input logic [7:0] gmii_txd_o,
  input logic       gmii_tx_en_o,
  input logic       gmii_tx_er_o,
  input logic       rx_stb_o,
  input logic       rx_dv_o,
  input logic       gmii_rx_dv_i
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!gmii_tx_en_o && !rx_stb_o && !rx_dv_o && !tx_underrun_o));

  p_hold_byte_r3: assert property (@(posedge clk) disable iff (rst)
    (gmii_tx_en_o && !tx_slot_o) |=> (gmii_tx_en_o && $stable(gmii_txd_o) && $stable(gmii_tx_er_o)));

  p_idle_slot_r4: assert property (@(posedge clk) disable iff (rst)
    !gmii_tx_en_o |-> tx_slot_o);

  p_underrun_clear_r6: assert property (@(posedge clk) disable iff (rst)
    tx_underrun_o |-> (!gmii_tx_en_o && !gmii_tx_er_o && gmii_txd_o == 8'h00));

  p_underrun_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    tx_underrun_o |=> !tx_underrun_o);

  p_stb_in_frame_r9: assert property (@(posedge clk) disable iff (rst)
    rx_stb_o |-> rx_dv_o);

  p_dv_fall_r9: assert property (@(posedge clk) disable iff (rst)
    !gmii_rx_dv_i |=> !rx_dv_o);
endmodule

bind gmii_rate_adapter gra_checker u_gra_checker (
  .clk           (clk),
  .rst           (rst),
  .tx_slot_o     (tx_slot_o),
  .tx_underrun_o (tx_underrun_o),
  .gmii_txd_o    (gmii_txd_o),
  .gmii_tx_en_o  (gmii_tx_en_o),
  .gmii_tx_er_o  (gmii_tx_er_o),
  .rx_stb_o      (rx_stb_o),
  .rx_dv_o       (rx_dv_o),
  .gmii_rx_dv_i  (gmii_rx_dv_i)
);

// File: tb/gmii_rate_adapter_bench.sv
module gmii_rate_adapter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] speed_i = 2'b10;
  logic       tx_stb_i = 1'b0, tx_en_i = 1'b0, tx_er_i = 1'b0;
  logic [7:0] tx_data_i = 8'h00;
  logic       tx_slot_o, tx_underrun_o, gmii_tx_en_o, gmii_tx_er_o;
  logic [7:0] gmii_txd_o;
  logic [7:0] gmii_rxd_i = 8'h00;
  logic       gmii_rx_dv_i = 1'b0, gmii_rx_er_i = 1'b0;
  logic       rx_stb_o, rx_er_o, rx_dv_o;
  logic [7:0] rx_data_o;

  int checks = 0;
  int errors = 0;
  int bench_rep = 1;
  int slot_hits = 0;
  int underruns = 0;
  bit done = 0;
  logic [8:0] txq[$];
  logic [8:0] rxq[$];

  always #5 clk = ~clk;

  gmii_rate_adapter u_gmii_rate_adapter (.*);

  function automatic int rep_of(input logic [1:0] s);
    return s[1] ? 1 : (s[0] ? 10 : 100);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (gmii_tx_en_o) begin
        if (tx_slot_o) slot_hits++;
        if (txq.size() == 0) chk(0, "R3 extra line beat", {gmii_tx_er_o, gmii_txd_o}, 0);
        else begin
          logic [8:0] e;
          e = txq.pop_front();
          chk({gmii_tx_er_o, gmii_txd_o} == e, "R2/R3 line beat", {gmii_tx_er_o, gmii_txd_o}, e);
        end
      end
      if (rx_stb_o) begin
        if (rxq.size() == 0) chk(0, "R7 extra rx byte", {rx_er_o, rx_data_o}, 0);
        else begin
          logic [8:0] e;
          e = rxq.pop_front();
          chk({rx_er_o, rx_data_o} == e, "R7/R8 rx byte", {rx_er_o, rx_data_o}, e);
          chk(rx_dv_o == 1'b1, "R9 dv with strobe", rx_dv_o, 1);
        end
      end
      if (tx_underrun_o) underruns++;
    end
  end

  task automatic set_speed(input logic [1:0] s);
    speed_i   = s;
    bench_rep = rep_of(s);
    repeat (3) @(negedge clk);
  endtask

  // Driver: one byte per observed slot
  task automatic tx_frame(input int n, input logic [7:0] base, input int er_idx,
                          input bit junk, input bit stop_early);
    int i;
    i = 0;
    while (i <= n) begin
      @(negedge clk);
      if (tx_slot_o) begin
        if (i < n) begin
          tx_stb_i = 1; tx_en_i = 1; tx_data_i = base + 8'(i); tx_er_i = (i == er_idx);
          for (int k = 0; k < bench_rep; k++) txq.push_back({tx_er_i, tx_data_i});
        end else if (!stop_early) begin
          tx_stb_i = 1; tx_en_i = 0; tx_er_i = 0;
        end else tx_stb_i = 0;
        i++;
      end else if (junk) begin
        tx_stb_i = 1; tx_en_i = 1; tx_data_i = 8'hEE; tx_er_i = 1;
      end else tx_stb_i = 0;
    end
    @(negedge clk);
    tx_stb_i = 0; tx_en_i = 0; tx_er_i = 0; tx_data_i = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rx_frame(input int n, input logic [7:0] base, input int er_idx, input int shorten);
    for (int i = 0; i < n; i++) begin
      int len;
      len = (i == 0) ? bench_rep - shorten : bench_rep;
      rxq.push_back({1'(i == er_idx), base + 8'(i)});
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        gmii_rx_dv_i = 1; gmii_rxd_i = base + 8'(i); gmii_rx_er_i = (i == er_idx);
      end
    end
    @(negedge clk);
    gmii_rx_dv_i = 0; gmii_rxd_i = 0; gmii_rx_er_i = 0;
    @(negedge clk);
    chk(rx_dv_o == 1'b0, "R9 dv falls after input", rx_dv_o, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(gmii_tx_en_o == 0 && gmii_tx_er_o == 0 && gmii_txd_o == 0, "R1 tx line idle", gmii_tx_en_o, 0);
    chk(tx_slot_o == 1, "R1 slot open", tx_slot_o, 1);
    chk(rx_stb_o == 0 && rx_dv_o == 0 && tx_underrun_o == 0, "R1 rx idle", rx_dv_o, 0);

    // R2/R3/R4 at each rate
    set_speed(2'b11);
    slot_hits = 0;
    tx_frame(6, 8'h10, 2, 0, 0);
    chk(txq.size() == 0, "R3 all gigabit beats", txq.size(), 0);
    chk(slot_hits == 6, "R4 slot per byte 1000", slot_hits, 6);
    set_speed(2'b01);
    slot_hits = 0;
    tx_frame(5, 8'h30, 4, 0, 0);
    chk(txq.size() == 0, "R2 100M beats", txq.size(), 0);
    chk(slot_hits == 5, "R4 slot per byte 100", slot_hits, 5);
    set_speed(2'b00);
    slot_hits = 0;
    tx_frame(3, 8'h50, 0, 0, 0);
    chk(txq.size() == 0, "R2 10M beats", txq.size(), 0);
    chk(slot_hits == 3, "R4 slot per byte 10", slot_hits, 3);

    // R5 off-slot strobes ignored
    set_speed(2'b01);
    tx_frame(4, 8'h70, -1, 1, 0);
    chk(txq.size() == 0, "R5 off-slot strobes ignored", txq.size(), 0);
    // R5 idle end marker ignored
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      tx_stb_i = 1; tx_en_i = 0; tx_er_i = 1; tx_data_i = 8'h0F;
    end
    @(negedge clk);
    tx_stb_i = 0; tx_er_i = 0; tx_data_i = 0;
    chk(gmii_tx_en_o == 0 && gmii_tx_er_o == 0 && gmii_txd_o == 0, "R5 idle marker no effect", gmii_tx_er_o, 0);

    // R6 underrun
    underruns = 0;
    tx_frame(2, 8'h90, -1, 0, 1);
    chk(underruns == 1, "R6 one underrun pulse", underruns, 1);
    chk(gmii_tx_en_o == 0 && txq.size() == 0, "R6 frame aborted", gmii_tx_en_o, 0);

    // R10 tx: speed change mid frame deferred
    set_speed(2'b00);
    fork
      tx_frame(2, 8'hA0, -1, 0, 0);
      begin repeat (30) @(negedge clk); speed_i = 2'b01; end
    join
    chk(txq.size() == 0, "R10 tx kept 10M", txq.size(), 0);
    bench_rep = 10;
    tx_frame(2, 8'hB0, -1, 0, 0);
    chk(txq.size() == 0, "R10 new rate after frame", txq.size(), 0);

    // R7 receive at each rate, R8 shortened first byte
    set_speed(2'b10);
    rx_frame(6, 8'hC0, 3, 0);
    chk(rxq.size() == 0, "R7 rx 1000 count", rxq.size(), 0);
    set_speed(2'b01);
    rx_frame(4, 8'hD0, 1, 2);
    chk(rxq.size() == 0, "R8 rx 100 short first", rxq.size(), 0);
    set_speed(2'b00);
    rx_frame(3, 8'hE0, -1, 2);
    chk(rxq.size() == 0, "R8 rx 10 short first", rxq.size(), 0);

    // R10 rx: change during receive deferred
    set_speed(2'b01);
    fork
      rx_frame(4, 8'h20, -1, 0);
      begin repeat (12) @(negedge clk); speed_i = 2'b10; end
    join
    chk(rxq.size() == 0, "R10 rx kept 100M", rxq.size(), 0);
    bench_rep = 1;
    rx_frame(5, 8'h40, 0, 0);
    chk(rxq.size() == 0, "R10 rx new rate", rxq.size(), 0);

    repeat (5) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule